// File: doc/BRIEF.md
# Lockable SVGA Extension Register File

This block is the indexed extension register file of a VGA-style graphics controller. Software reaches it through two ports on a simple synchronous bus. A write to the index port latches an 8-bit register number. Accesses through the data port then act on that latched number. Seven registers sit in the index window 0x09 to 0x0F:

| Index | Register |
|-------|----------|
| 0x09 | First bank offset |
| 0x0A | Second bank offset |
| 0x0B | Memory configuration |
| 0x0C | Video configuration |
| 0x0D | CRT control |
| 0x0E | Video control |
| 0x0F | Lock register |

The lock register holds a three-bit key. Unless that key is correct, the six registers below it can be neither read nor written.

The block drives several outputs to its neighbours: both bank offsets, the dual-bank enable bit and the two upper address bits of the display start and cursor start. A one-cycle request starts a mode-set sequence. This sequence returns the file to its single-bank power-on layout, and it does so even while software has the file locked. Any data access to an index outside the window is counted as illegal and is recorded in a sticky flag.

Top module: `svga_ext_regfile`

## Requirements
- R1: After reset:
  - both bank offsets, video configuration, CRT control, video control, the latched index and the illegal flag are zero;
  - the lock register reads 0x05, so the file starts unlocked;
  - memory configuration reads {SIZE,6'b0}.
- R2: A pulse on `idx_wr` latches `wdata` as the index. A `data_wr` writes `wdata` to the register at the index that was latched before that cycle, so a `data_wr` in the same cycle as `idx_wr` uses the old index. While `data_rd` is high, `rdata` combinationally shows the selected register, and it shows 0x00 whenever `data_rd` is low.
- R3: The file is unlocked exactly when lock register bits [2:0] equal 3'b101. While locked, writes to 0x09-0x0E are discarded and reads from them return 0x00. Index 0x0F is readable and fully writable (all 8 bits) in every lock state.
- R4: A write to memory configuration (0x0B) changes only bit 3, the dual-bank enable. Bits [7:6] hold the size code SIZE: 2'b01 for 256 KB, 2'b10 for 512 KB and 2'b11 for 1 MB. SIZE comes from parameter MEM_KB: a value at or below 256 selects 01, a value above 512 selects 11, and any other value selects 10. The default MEM_KB is 512.
- R5: `bank_a_off` and `bank_b_off` follow registers 0x09 and 0x0A. `dual_bank_en` follows bit 3 of 0x0B. Both `disp_start_hi` and `cursor_start_hi` follow bits [4:3] of CRT control (0x0D).
- R6: A data read or write at an index outside 0x09-0x0F reads 0x00 and changes no register. It sets `illegal_seen`, which stays set until reset.
- R7: A `modeset_start` pulse while idle raises `modeset_busy` from the next cycle for exactly 8 cycles. When `modeset_busy` falls:
  - both bank offsets are zero;
  - bit 3 of 0x0B is clear and the size field is kept;
  - 0x0C, 0x0D and 0x0E are zero;
  - the lock register holds the value it had before the sequence, and the sequence runs whatever that lock state was.
- R8: While `modeset_busy` is high, `data_wr` has no effect, and a further `modeset_start` is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| idx_wr | input | 1 | Index port write strobe |
| data_wr | input | 1 | Data port write strobe |
| data_rd | input | 1 | Data port read strobe |
| wdata | input | 8 | Write data for both ports |
| rdata | output | 8 | Combinational read data |
| modeset_start | input | 1 | Mode-set sequence request pulse |
| modeset_busy | output | 1 | Mode-set sequence in progress |
| bank_a_off | output | 8 | First bank offset |
| bank_b_off | output | 8 | Second bank offset |
| dual_bank_en | output | 1 | Second bank enable |
| disp_start_hi | output | 2 | Display start address bits [17:16] |
| cursor_start_hi | output | 2 | Cursor start address bits [17:16] |
| illegal_seen | output | 1 | Sticky out-of-window access flag |

## Verification
The bench builds the block with MEM_KB = 256. This makes the size field read 2'b01 instead of the default and exposes a preset that ignores the parameter.

With an 8-bit index and an 8-bit lock register, both spaces are swept in full:
- every one of the 256 lock values is tried against a protected write and read, so each wrong key is seen to block access;
- every one of the 256 indices is read with known register contents, so the decode window and its two edges are covered.

The mode-set sequence is run from a locked state with writes held against it, which covers the lock restore and the busy-time write blocking.

// File: rtl/svga_ext_pkg.sv
package svga_ext_pkg;

    localparam int DW = 8;

    localparam logic [2:0]    UNLOCK_KEY = 3'b101;
    localparam logic [DW-1:0] LOCK_RST   = 8'h05;
    localparam int            DUAL_BIT   = 3;

    typedef enum logic [2:0] {
        RID_BANK_A = 3'd0,
        RID_BANK_B = 3'd1,
        RID_MEMCFG = 3'd2,
        RID_VIDCFG = 3'd3,
        RID_CRTCTL = 3'd4,
        RID_VIDCTL = 3'd5,
        RID_LOCK   = 3'd6,
        RID_NONE   = 3'd7
    } reg_id_e;

    typedef enum logic [3:0] {
        SEQ_IDLE,
        SEQ_SAVE,
        SEQ_CLR_BANK_A,
        SEQ_CLR_BANK_B,
        SEQ_CLR_DUAL,
        SEQ_CLR_VIDCFG,
        SEQ_CLR_CRT,
        SEQ_CLR_VIDCTL,
        SEQ_RESTORE
    } seq_step_e;

    typedef struct packed {
        logic [DW-1:0] index;
        logic [DW-1:0] bank_a;
        logic [DW-1:0] bank_b;
        logic [DW-1:0] memcfg;
        logic [DW-1:0] vidcfg;
        logic [DW-1:0] crtctl;
        logic [DW-1:0] vidctl;
        logic [DW-1:0] lock;
        logic [DW-1:0] saved_lock;
        logic          illegal;
    } ext_regs_t;

    // Installed-memory code held in the top two bits of memory configuration
    function automatic logic [1:0] size_code(input int kb);
        if (kb <= 256)      return 2'b01;
        else if (kb > 512)  return 2'b11;
        else                return 2'b10;
    endfunction

endpackage

// File: rtl/ext_index_decode.sv
module ext_index_decode
    import svga_ext_pkg::*;
#(
    parameter int              IW       = 8,
    parameter logic [IW-1:0]   BASE_IDX = 8'h09,
    parameter int              NREGS    = 7
) (
    input  logic [IW-1:0] idx,
    input  logic          unlocked,
    output reg_id_e       rid,
    output logic          in_range,
    output logic          access_ok
);
    localparam logic [IW-1:0] LAST_IDX = BASE_IDX + IW'(NREGS - 1);

    logic [IW-1:0] offset;

    always_comb begin
        offset   = idx - BASE_IDX;
        in_range = (idx >= BASE_IDX) && (idx <= LAST_IDX);
        rid      = in_range ? reg_id_e'(offset[2:0]) : RID_NONE;
        // Lock register stays reachable; the rest need the key
        access_ok = in_range && (unlocked || (rid == RID_LOCK));
    end
endmodule

// File: rtl/ext_modeset_seq.sv
module ext_modeset_seq
    import svga_ext_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      start,
    output seq_step_e step,
    output logic      busy
);
    seq_step_e state_d, state_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SEQ_IDLE:       state_d = start ? SEQ_SAVE : SEQ_IDLE;
            SEQ_SAVE:       state_d = SEQ_CLR_BANK_A;
            SEQ_CLR_BANK_A: state_d = SEQ_CLR_BANK_B;
            SEQ_CLR_BANK_B: state_d = SEQ_CLR_DUAL;
            SEQ_CLR_DUAL:   state_d = SEQ_CLR_VIDCFG;
            SEQ_CLR_VIDCFG: state_d = SEQ_CLR_CRT;
            SEQ_CLR_CRT:    state_d = SEQ_CLR_VIDCTL;
            SEQ_CLR_VIDCTL: state_d = SEQ_RESTORE;
            SEQ_RESTORE:    state_d = SEQ_IDLE;
            default:        state_d = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SEQ_IDLE;
        else        state_q <= state_d;
    end

    assign step = state_q;
    assign busy = (state_q != SEQ_IDLE);

    // R7: every busy step lasts exactly one cycle
    a_r7_step_advances: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != SEQ_IDLE) |=> (state_q != $past(state_q)));

    // R8: a request during the sequence never restarts it
    a_r8_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> (state_q != SEQ_SAVE));
endmodule

// File: rtl/svga_ext_regfile.sv
module svga_ext_regfile
    import svga_ext_pkg::*;
#(
    parameter int            MEM_KB   = 512,
    parameter logic [7:0]    BASE_IDX = 8'h09
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       idx_wr,
    input  logic       data_wr,
    input  logic       data_rd,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    input  logic       modeset_start,
    output logic       modeset_busy,
    output logic [7:0] bank_a_off,
    output logic [7:0] bank_b_off,
    output logic       dual_bank_en,
    output logic [1:0] disp_start_hi,
    output logic [1:0] cursor_start_hi,
    output logic       illegal_seen
);
    localparam logic [1:0]    SIZE       = size_code(MEM_KB);
    localparam logic [DW-1:0] MEMCFG_RST = {SIZE, 6'b0};
    localparam logic [DW-1:0] DUAL_MASK  = DW'(1) << DUAL_BIT;

    localparam ext_regs_t REGS_RST = '{
        index:      '0,
        bank_a:     '0,
        bank_b:     '0,
        memcfg:     MEMCFG_RST,
        vidcfg:     '0,
        crtctl:     '0,
        vidctl:     '0,
        lock:       LOCK_RST,
        saved_lock: '0,
        illegal:    1'b0
    };

    ext_regs_t r_d, r_q;

    reg_id_e   rid;
    logic      in_range;
    logic      access_ok;
    logic      unlocked;
    seq_step_e step;
    logic      busy;
    logic [7:0] rd_val;

    assign unlocked = (r_q.lock[2:0] == UNLOCK_KEY);

    ext_index_decode #(
        .IW       (DW),
        .BASE_IDX (BASE_IDX),
        .NREGS    (7)
    ) u_dec (
        .idx       (r_q.index),
        .unlocked  (unlocked),
        .rid       (rid),
        .in_range  (in_range),
        .access_ok (access_ok)
    );

    ext_modeset_seq u_seq (
        .clk   (clk),
        .rst_n (rst_n),
        .start (modeset_start),
        .step  (step),
        .busy  (busy)
    );

    // Next-state computation
    always_comb begin
        r_d = r_q;

        if (idx_wr)
            r_d.index = wdata;

        if (data_wr && !busy) begin
            if (!in_range) begin
                r_d.illegal = 1'b1;
            end else if (access_ok) begin
                unique case (rid)
                    RID_BANK_A: r_d.bank_a = wdata;
                    RID_BANK_B: r_d.bank_b = wdata;
                    RID_MEMCFG: r_d.memcfg = (r_q.memcfg & ~DUAL_MASK) | (wdata & DUAL_MASK);
                    RID_VIDCFG: r_d.vidcfg = wdata;
                    RID_CRTCTL: r_d.crtctl = wdata;
                    RID_VIDCTL: r_d.vidctl = wdata;
                    RID_LOCK:   r_d.lock   = wdata;
                    default:    ;
                endcase
            end
        end

        if (data_rd && !in_range)
            r_d.illegal = 1'b1;

        unique case (step)
            SEQ_SAVE: begin
                r_d.saved_lock = r_q.lock;
                r_d.lock       = LOCK_RST;
            end
            SEQ_CLR_BANK_A: r_d.bank_a = '0;
            SEQ_CLR_BANK_B: r_d.bank_b = '0;
            SEQ_CLR_DUAL:   r_d.memcfg = r_q.memcfg & ~DUAL_MASK;
            SEQ_CLR_VIDCFG: r_d.vidcfg = '0;
            SEQ_CLR_CRT:    r_d.crtctl = '0;
            SEQ_CLR_VIDCTL: r_d.vidctl = '0;
            SEQ_RESTORE:    r_d.lock   = r_q.saved_lock;
            default:        ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= REGS_RST;
        else        r_q <= r_d;
    end

    // Read path
    always_comb begin
        rd_val = '0;
        if (data_rd && access_ok) begin
            unique case (rid)
                RID_BANK_A: rd_val = r_q.bank_a;
                RID_BANK_B: rd_val = r_q.bank_b;
                RID_MEMCFG: rd_val = r_q.memcfg;
                RID_VIDCFG: rd_val = r_q.vidcfg;
                RID_CRTCTL: rd_val = r_q.crtctl;
                RID_VIDCTL: rd_val = r_q.vidctl;
                RID_LOCK:   rd_val = r_q.lock;
                default:    rd_val = '0;
            endcase
        end
    end

    assign rdata           = rd_val;
    assign modeset_busy    = busy;
    assign bank_a_off      = r_q.bank_a;
    assign bank_b_off      = r_q.bank_b;
    assign dual_bank_en    = r_q.memcfg[DUAL_BIT];
    assign disp_start_hi   = r_q.crtctl[4:3];
    assign cursor_start_hi = r_q.crtctl[4:3];
    assign illegal_seen    = r_q.illegal;

    // R3: protected registers read as zero while locked
    a_r3_locked_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (data_rd && !unlocked && in_range && rid != RID_LOCK) |-> (rdata == 8'h00));

    // R3: a locked write leaves every protected register untouched
    a_r3_locked_write_held: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && !busy && !unlocked && in_range && rid != RID_LOCK)
        |=> $stable({r_q.bank_a, r_q.bank_b, r_q.memcfg, r_q.vidcfg, r_q.crtctl, r_q.vidctl}));

    // R4: memory configuration bits other than bit 3 never move
    a_r4_memcfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ({r_q.memcfg[7:4], r_q.memcfg[2:0]} == $past({r_q.memcfg[7:4], r_q.memcfg[2:0]})));

    // R6: the illegal flag is sticky
    a_r6_illegal_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.illegal |=> r_q.illegal);

    // R6: an out-of-window read returns zero
    a_r6_illegal_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (data_rd && !in_range) |-> (rdata == 8'h00));

    // R7: the lock value is back in place when the sequence ends
    a_r7_lock_restored: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (r_q.lock == r_q.saved_lock));

    // R8: data writes are blocked during the sequence
    a_r8_busy_write_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && data_wr && step == SEQ_RESTORE) |=> (r_q.bank_a == 8'h00));
endmodule

// File: tb/sim_svga_ext_regfile.sv
`timescale 1ns/1ps
module sim_svga_ext_regfile;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       idx_wr = 1'b0, data_wr = 1'b0, data_rd = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       modeset_start = 1'b0;
    logic       modeset_busy;
    logic [7:0] bank_a_off, bank_b_off;
    logic       dual_bank_en;
    logic [1:0] disp_start_hi, cursor_start_hi;
    logic       illegal_seen;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    localparam logic [7:0] MEMBASE = 8'h40; // size code 01 for 256 KB

    always #2.5 clk = ~clk;

    svga_ext_regfile #(.MEM_KB(256)) u0 (
        .clk(clk), .rst_n(rst_n), .idx_wr(idx_wr), .data_wr(data_wr), .data_rd(data_rd),
        .wdata(wdata), .rdata(rdata), .modeset_start(modeset_start), .modeset_busy(modeset_busy),
        .bank_a_off(bank_a_off), .bank_b_off(bank_b_off), .dual_bank_en(dual_bank_en),
        .disp_start_hi(disp_start_hi), .cursor_start_hi(cursor_start_hi), .illegal_seen(illegal_seen)
    );

    task automatic check(input string req, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic set_idx(input logic [7:0] i);
        @(negedge clk); idx_wr = 1'b1; wdata = i;
        @(negedge clk); idx_wr = 1'b0;
    endtask

    task automatic wr(input logic [7:0] i, input logic [7:0] v);
        set_idx(i);
        data_wr = 1'b1; wdata = v;
        @(negedge clk); data_wr = 1'b0;
    endtask

    task automatic rd_cur(output logic [7:0] v);
        data_rd = 1'b1;
        #1 v = rdata;
        @(negedge clk); data_rd = 1'b0;
    endtask

    task automatic rd(input logic [7:0] i, output logic [7:0] v);
        set_idx(i);
        rd_cur(v);
    endtask

    function automatic logic [7:0] exp_read(input logic [7:0] i, input logic [7:0] m [7]);
        if (i >= 8'h09 && i <= 8'h0F) return m[i - 8'h09];
        return 8'h00;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        logic [7:0] model [7];
        logic [7:0] vidcfg_m;
        int busy_cnt;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 bank_a", bank_a_off, 0);
        check("R1 bank_b", bank_b_off, 0);
        check("R1 dual", dual_bank_en, 0);
        check("R1 disp_hi", disp_start_hi, 0);
        check("R1 illegal", illegal_seen, 0);
        check("R1 busy", modeset_busy, 0);
        rd(8'h0F, v); check("R1 lock", v, 8'h05);
        rd(8'h0B, v); check("R1 memcfg size", v, MEMBASE);
        for (int i = 8'h09; i <= 8'h0E; i++) begin
            if (i != 8'h0B) begin
                rd(8'(i), v); check("R1 reg zero", v, 0);
            end
        end

        // R2 same-cycle index and data write uses old index; rdata zero when idle
        set_idx(8'h0C);
        idx_wr = 1'b1; data_wr = 1'b1; wdata = 8'h0E;
        @(negedge clk); idx_wr = 1'b0; data_wr = 1'b0;
        check("R2 rdata idle", rdata, 0);
        rd_cur(v); check("R2 new index read", v, 8'h00);
        rd(8'h0C, v); check("R2 old index written", v, 8'h0E);
        vidcfg_m = 8'h0E;

        // R4 only bit 3 writable
        wr(8'h0B, 8'hFF); rd(8'h0B, v); check("R4 memcfg set", v, MEMBASE | 8'h08);
        check("R5 dual on", dual_bank_en, 1);
        wr(8'h0B, 8'h00); rd(8'h0B, v); check("R4 memcfg clr", v, MEMBASE);
        check("R5 dual off", dual_bank_en, 0);

        // R5 outputs
        wr(8'h09, 8'hA5); check("R5 bank_a", bank_a_off, 8'hA5);
        wr(8'h0A, 8'h3C); check("R5 bank_b", bank_b_off, 8'h3C);
        for (int c = 0; c < 4; c++) begin
            wr(8'h0D, 8'(c << 3) | 8'h04);
            check("R5 disp_hi", disp_start_hi, c);
            check("R5 cursor_hi", cursor_start_hi, c);
        end

        // R3 full lock sweep
        for (int l = 0; l < 256; l++) begin
            logic [7:0] pat;
            pat = 8'(l) ^ 8'h5A;
            wr(8'h0F, 8'(l));
            rd(8'h0F, v); check("R3 lock readback", v, l);
            wr(8'h0C, pat);
            rd(8'h0C, v);
            check("R3 locked read", v, ((l & 7) == 5) ? pat : 8'h00);
            if ((l & 7) == 5) vidcfg_m = pat;
            wr(8'h0F, 8'h05);
            rd(8'h0C, v); check("R3 write gate", v, vidcfg_m);
        end
        check("R6 no illegal yet", illegal_seen, 0);

        // R6 illegal writes and full index read sweep
        wr(8'h09, 8'h11); wr(8'h0A, 8'h22); wr(8'h0B, 8'hFF);
        wr(8'h0C, 8'h33); wr(8'h0D, 8'h1C); wr(8'h0E, 8'h44);
        wr(8'h08, 8'hFF); wr(8'h10, 8'hFF); wr(8'h00, 8'hFF); wr(8'hFF, 8'hFF);
        check("R6 illegal set", illegal_seen, 1);
        model = '{8'h11, 8'h22, MEMBASE | 8'h08, 8'h33, 8'h1C, 8'h44, 8'h05};
        for (int i = 0; i < 256; i++) begin
            rd(8'(i), v); check("R6 index sweep", v, exp_read(8'(i), model));
        end
        check("R6 illegal sticky", illegal_seen, 1);

        // R7/R8 mode-set from a locked state with blocked writes
        wr(8'h0F, 8'h02);
        set_idx(8'h09);
        modeset_start = 1'b1;
        @(negedge clk); modeset_start = 1'b0;
        data_wr = 1'b1; wdata = 8'h77;
        busy_cnt = 0;
        for (int t = 0; t < 40; t++) begin
            if (modeset_busy) busy_cnt++;
            if (t == 3) modeset_start = 1'b1;
            if (t == 4) modeset_start = 1'b0;
            if (!modeset_busy && t > 0) break;
            @(negedge clk);
        end
        data_wr = 1'b0;
        @(negedge clk);
        check("R7 busy length", busy_cnt, 8);
        check("R8 restart ignored", modeset_busy, 0);
        check("R8 bank_a blocked", bank_a_off, 0);
        check("R7 bank_b", bank_b_off, 0);
        check("R7 dual", dual_bank_en, 0);
        check("R7 disp_hi", disp_start_hi, 0);
        rd(8'h0F, v); check("R7 lock restored", v, 8'h02);
        rd(8'h09, v); check("R7 locked read", v, 0);
        wr(8'h0F, 8'h05);
        for (int i = 8'h09; i <= 8'h0E; i++) begin
            rd(8'(i), v); check("R7 cleared", v, (i == 8'h0B) ? MEMBASE : 8'h00);
        end

        done = 1'b1;
        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule